// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the register exchange between a host bus and the local processor of an 8042-style keyboard controller. The host side has a chip select, read and write strobes, one address bit and an 8-bit data path. The local processor side has its own read and write strobes, a select bit, and 8-bit data paths. Two one-byte buffers carry the traffic:

- The inbound buffer carries host bytes toward the processor.
- The outbound buffer carries processor bytes toward the host.

A shared status byte reports the fill state of each buffer and whether the last host byte was a command or data. Its remaining bits are free for firmware use.

Each buffer is a two-state machine with the states SLOT_EMPTY and SLOT_FULL. A load moves it from SLOT_EMPTY to SLOT_FULL, or keeps it in SLOT_FULL with new content. A take without a load moves it from SLOT_FULL to SLOT_EMPTY. A load and a take in the same cycle keep it in SLOT_FULL.

- The inbound buffer is loaded by a host write and taken by a processor data read.
- The outbound buffer is loaded by a processor data write and taken by a host data read.

Two level outputs report the buffer states. One is an interrupt toward the host while outbound data waits. The other is an interrupt toward the processor while inbound data waits. Each one has its own enable input.

Top module: `kbc_host_mailbox`

## Requirements
- R1: After reset, the status byte reads 0x00 and both interrupt outputs are low.
- R2: A host write (`hst_cs`=1, `hst_wr`=1) with `hst_a0`=0 stores `hst_wdata` in the inbound buffer. It sets status bit 1 (inbound full) and clears status bit 3 (command flag).
- R3: A host write with `hst_a0`=1 stores the byte, sets status bit 1 and sets status bit 3 to 1.
- R4: A host write while status bit 1 is already set replaces the stored byte and leaves bit 1 set.
- R5: A processor read with `cpu_sel`=0 returns the inbound byte on `cpu_rdata` in the same cycle, and clears status bit 1 at that clock edge.
- R6: A processor write with `cpu_sel`=0 loads the outbound buffer and sets status bit 0 (outbound full). A host read with `hst_a0`=0 returns that byte on `hst_rdata` and clears bit 0 at that edge.
- R7: `kbd_host_irq` is high exactly when status bit 0 is set and `kbd_host_irq_en` is 1.
- R8: `cpu_ibf_irq` is high exactly when status bit 1 is set and `cpu_ibf_irq_en` is 1.
- R9: A host read with `hst_a0`=1, or a processor read with `cpu_sel`=1, returns the status byte and changes nothing.
- R10: A processor write with `cpu_sel`=1 sets status bits 2, 4, 5, 6, 7 and bit 3 from `cpu_wdata`. Bits 0 and 1 of that write are ignored.
- R11: When a load and a take of the same buffer fall in one cycle, the load wins: the buffer stays full and holds the new byte. A host write overrides a same-cycle processor write of bit 3.
- R12: Host strobes with `hst_cs`=0 have no effect, and `hst_rdata` reads 0 unless `hst_cs` and `hst_rd` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_cs | input | 1 | Host chip select |
| hst_rd | input | 1 | Host read strobe, one cycle per access |
| hst_wr | input | 1 | Host write strobe, one cycle per access |
| hst_a0 | input | 1 | Host address bit: 1 = status / command, 0 = data |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, combinational |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_sel | input | 1 | Processor select: 1 = status, 0 = data buffer |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data, combinational |
| kbd_host_irq_en | input | 1 | Enable for the host interrupt |
| cpu_ibf_irq_en | input | 1 | Enable for the processor interrupt |
| kbd_host_irq | output | 1 | Outbound data waiting for the host |
| cpu_ibf_irq | output | 1 | Inbound data waiting for the processor |

## Verification
The inbound path is driven in three ways:
- a data write followed by a command write, which shows whether the command flag follows the address bit;
- a second write before the processor drains the buffer, which shows overwrite from loss of the flag;
- a processor drain, which separates a taken buffer from a held one.

The outbound path is driven with the interrupt enabled and disabled, which shows gating apart from the flag itself. Same-cycle load and take on both buffers confirms that the load wins. A status write of all ones and of zero, and strobes with chip select low, separate writable bits from the fixed flag bits and from ignored accesses.

// File: rtl/kbc_mbx_pkg.sv
package kbc_mbx_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    localparam int STAT_OUT_FULL = 0;
    localparam int STAT_IN_FULL  = 1;
    localparam int STAT_CMD      = 3;

endpackage

// File: rtl/kbc_mbx_slot.sv
module kbc_mbx_slot
    import kbc_mbx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          take,
    input  logic [DW-1:0] din,
    output logic          full,
    output logic [DW-1:0] dout
);

    slot_state_e   state_q, state_d;
    logic [DW-1:0] data_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (load) state_d = SLOT_FULL;
            SLOT_FULL:  if (take && !load) state_d = SLOT_EMPTY;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data_q <= '0;
        else if (load) data_q <= din;
    end

    // outputs
    always_comb begin
        full = (state_q == SLOT_FULL);
        dout = data_q;
    end

    AST_LOAD_FILLS:   assert property (@(posedge clk) disable iff (!rst_n) load |=> full);                       // R2
    AST_TAKE_DRAINS:  assert property (@(posedge clk) disable iff (!rst_n) (take && !load) |=> !full);           // R5
    AST_LOAD_WINS:    assert property (@(posedge clk) disable iff (!rst_n) (take && load) |=> (full && dout == $past(din))); // R11
    AST_DATA_HELD:    assert property (@(posedge clk) disable iff (!rst_n) !load |=> $stable(dout));             // R4

endmodule

// File: rtl/kbc_mbx_status.sv
module kbc_mbx_status
    import kbc_mbx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_a0,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          out_full,
    input  logic          in_full,
    output logic [DW-1:0] status
);

    localparam logic [DW-1:0] FIXED_MASK = DW'((1 << STAT_OUT_FULL) | (1 << STAT_IN_FULL) | (1 << STAT_CMD));
    localparam logic [DW-1:0] USER_MASK  = ~FIXED_MASK;

    logic          cmd_q;
    logic [DW-1:0] user_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cmd_q <= 1'b0;
        else if (host_wr) cmd_q <= host_a0;
        else if (cpu_wr)  cmd_q <= cpu_wdata[STAT_CMD];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      user_q <= '0;
        else if (cpu_wr) user_q <= cpu_wdata & USER_MASK;
    end

    always_comb begin
        status                = user_q;
        status[STAT_CMD]      = cmd_q;
        status[STAT_IN_FULL]  = in_full;
        status[STAT_OUT_FULL] = out_full;
    end

    AST_CMD_FROM_HOST: assert property (@(posedge clk) disable iff (!rst_n) host_wr |=> status[STAT_CMD] == $past(host_a0)); // R3
    AST_USER_STABLE:   assert property (@(posedge clk) disable iff (!rst_n) !cpu_wr |=> $stable(status & USER_MASK));        // R10

endmodule

// File: rtl/kbc_host_mailbox.sv
module kbc_host_mailbox
    import kbc_mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_cs,
    input  logic              hst_rd,
    input  logic              hst_wr,
    input  logic              hst_a0,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              cpu_sel,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              kbd_host_irq_en,
    input  logic              cpu_ibf_irq_en,
    output logic              kbd_host_irq,
    output logic              cpu_ibf_irq
);

    logic              host_wr_ev, host_rd_ev, host_rd_data;
    logic              cpu_rd_data, cpu_wr_data, cpu_wr_stat;
    logic              in_full, out_full;
    logic [DATA_W-1:0] in_byte, out_byte, status;

    always_comb begin
        host_wr_ev   = hst_cs && hst_wr;
        host_rd_ev   = hst_cs && hst_rd;
        host_rd_data = host_rd_ev && !hst_a0;
        cpu_rd_data  = cpu_rd && !cpu_sel;
        cpu_wr_data  = cpu_wr && !cpu_sel;
        cpu_wr_stat  = cpu_wr && cpu_sel;
    end

    kbc_mbx_slot #(.DW(DATA_W)) u_in_slot (
        .clk  (clk),
        .rst_n(rst_n),
        .load (host_wr_ev),
        .take (cpu_rd_data),
        .din  (hst_wdata),
        .full (in_full),
        .dout (in_byte)
    );

    kbc_mbx_slot #(.DW(DATA_W)) u_out_slot (
        .clk  (clk),
        .rst_n(rst_n),
        .load (cpu_wr_data),
        .take (host_rd_data),
        .din  (cpu_wdata),
        .full (out_full),
        .dout (out_byte)
    );

    kbc_mbx_status #(.DW(DATA_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_wr  (host_wr_ev),
        .host_a0  (hst_a0),
        .cpu_wr   (cpu_wr_stat),
        .cpu_wdata(cpu_wdata),
        .out_full (out_full),
        .in_full  (in_full),
        .status   (status)
    );

    always_comb begin
        hst_rdata    = host_rd_ev ? (hst_a0 ? status : out_byte) : '0;
        cpu_rdata    = cpu_rd ? (cpu_sel ? status : in_byte) : '0;
        kbd_host_irq = out_full && kbd_host_irq_en;
        cpu_ibf_irq  = in_full && cpu_ibf_irq_en;
    end

    AST_HOST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_data && !cpu_wr_data && kbd_host_irq_en) |=> !kbd_host_irq);                  // R6
    AST_FLAGS_RO:       assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_stat && !host_wr_ev && !cpu_rd_data) |=> status[STAT_IN_FULL] == $past(status[STAT_IN_FULL])); // R10
    AST_NO_CS_IGNORED:  assert property (@(posedge clk) disable iff (!rst_n)
        (!hst_cs && !cpu_rd && !cpu_wr) |=> $stable(status));                                   // R12
    AST_STATUS_RD_PURE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_ev && hst_a0 && !hst_wr && !cpu_rd && !cpu_wr) |=> $stable(status));          // R9

endmodule

// File: tb/kbc_host_mailbox_tb.sv
module kbc_host_mailbox_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hst_cs = 0, hst_rd = 0, hst_wr = 0, hst_a0 = 0;
    logic [7:0] hst_wdata = '0;
    logic [7:0] hst_rdata;
    logic       cpu_rd = 0, cpu_wr = 0, cpu_sel = 0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       kbd_host_irq_en = 0, cpu_ibf_irq_en = 0;
    logic       kbd_host_irq, cpu_ibf_irq;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    kbc_host_mailbox u_dut (
        .clk(clk), .rst_n(rst_n),
        .hst_cs(hst_cs), .hst_rd(hst_rd), .hst_wr(hst_wr), .hst_a0(hst_a0),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .kbd_host_irq_en(kbd_host_irq_en), .cpu_ibf_irq_en(cpu_ibf_irq_en),
        .kbd_host_irq(kbd_host_irq), .cpu_ibf_irq(cpu_ibf_irq)
    );

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", rq, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        hst_cs = 0; hst_rd = 0; hst_wr = 0; cpu_rd = 0; cpu_wr = 0;
    endtask

    task automatic host_write(input logic a0, input logic [7:0] d);
        @(negedge clk);
        hst_cs = 1; hst_wr = 1; hst_a0 = a0; hst_wdata = d;
        idle();
    endtask

    task automatic host_read(input logic a0, output logic [7:0] d);
        @(negedge clk);
        hst_cs = 1; hst_rd = 1; hst_a0 = a0;
        #1 d = hst_rdata;
        idle();
    endtask

    task automatic cpu_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1; cpu_sel = sel; cpu_wdata = d;
        idle();
    endtask

    task automatic cpu_read(input logic sel, output logic [7:0] d);
        @(negedge clk);
        cpu_rd = 1; cpu_sel = sel;
        #1 d = cpu_rdata;
        idle();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        host_read(1, v);     chk("R1 host status", v, 8'h00);
        cpu_read(1, v);      chk("R1 cpu status", v, 8'h00);
        chk("R1 host irq", {7'd0, kbd_host_irq}, 8'h00);
        chk("R1 cpu irq", {7'd0, cpu_ibf_irq}, 8'h00);
        chk("R12 idle rdata", hst_rdata, 8'h00);
    endtask

    task automatic t_inbound();
        logic [7:0] v;
        cpu_ibf_irq_en = 1;
        host_write(0, 8'h5A);
        host_read(1, v);     chk("R2 data write status", v, 8'h02);
        chk("R8 irq enabled", {7'd0, cpu_ibf_irq}, 8'h01);
        cpu_ibf_irq_en = 0; #1;
        chk("R8 irq gated", {7'd0, cpu_ibf_irq}, 8'h00);
        cpu_ibf_irq_en = 1;
        host_write(1, 8'hC3);
        host_read(1, v);     chk("R3 R4 command overwrite status", v, 8'h0A);
        cpu_read(0, v);      chk("R4 R5 cpu reads latest byte", v, 8'hC3);
        host_read(1, v);     chk("R5 drained status", v, 8'h08);
        chk("R8 irq after drain", {7'd0, cpu_ibf_irq}, 8'h00);
    endtask

    task automatic t_outbound();
        logic [7:0] v;
        kbd_host_irq_en = 1;
        cpu_write(0, 8'h77);
        cpu_read(1, v);      chk("R6 out flag", v & 8'h03, 8'h01);
        chk("R7 irq on", {7'd0, kbd_host_irq}, 8'h01);
        kbd_host_irq_en = 0; #1;
        chk("R7 irq gated", {7'd0, kbd_host_irq}, 8'h00);
        kbd_host_irq_en = 1;
        host_read(0, v);     chk("R6 host data", v, 8'h77);
        cpu_read(1, v);      chk("R6 out flag cleared", v & 8'h03, 8'h00);
        chk("R7 irq off", {7'd0, kbd_host_irq}, 8'h00);
    endtask

    task automatic t_status_write();
        logic [7:0] v;
        cpu_write(1, 8'hFF);
        host_read(1, v);     chk("R10 all ones", v, 8'hFC);
        host_read(1, v);     chk("R9 repeat read unchanged", v, 8'hFC);
        cpu_read(1, v);      chk("R9 cpu status read", v, 8'hFC);
        cpu_write(1, 8'h00);
        host_read(1, v);     chk("R10 cleared", v, 8'h00);
    endtask

    task automatic t_no_cs();
        logic [7:0] v;
        @(negedge clk);
        hst_cs = 0; hst_wr = 1; hst_a0 = 1; hst_wdata = 8'hEE;
        idle();
        cpu_write(0, 8'h31);
        @(negedge clk);
        hst_cs = 0; hst_rd = 1; hst_a0 = 0;
        #1 chk("R12 rdata without cs", hst_rdata, 8'h00);
        idle();
        host_read(1, v);     chk("R12 no effect", v, 8'h01);
        host_read(0, v);     chk("R12 out byte kept", v, 8'h31);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        host_write(0, 8'h11);
        @(negedge clk);
        hst_cs = 1; hst_wr = 1; hst_a0 = 0; hst_wdata = 8'h22;
        cpu_rd = 1; cpu_sel = 0;
        #1 chk("R11 cpu sees old byte", cpu_rdata, 8'h11);
        idle();
        host_read(1, v);     chk("R11 in stays full", v & 8'h02, 8'h02);
        cpu_read(0, v);      chk("R11 new byte kept", v, 8'h22);
        cpu_write(0, 8'h40);
        @(negedge clk);
        cpu_wr = 1; cpu_sel = 0; cpu_wdata = 8'h41;
        hst_cs = 1; hst_rd = 1; hst_a0 = 0;
        #1 chk("R11 host sees old byte", hst_rdata, 8'h40);
        idle();
        chk("R11 out irq kept", {7'd0, kbd_host_irq}, 8'h01);
        host_read(0, v);     chk("R11 out new byte", v, 8'h41);
        @(negedge clk);
        hst_cs = 1; hst_wr = 1; hst_a0 = 1; hst_wdata = 8'h00;
        cpu_wr = 1; cpu_sel = 1; cpu_wdata = 8'h00;
        idle();
        cpu_read(0, v);
        host_read(1, v);     chk("R11 host wins command flag", v, 8'h08);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_inbound();
        t_outbound();
        t_status_write();
        t_no_cs();
        t_same_cycle();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=below 20000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule